// File: doc/BRIEF.md
# Full-map directory home controller

This block sits at the home node of a distributed shared-memory machine and keeps coherence state for a set of memory blocks. Each block has one presence bit per node and a dirty bit. Any node may send a read or a write (ownership) request for a block.

Requests that can be served from memory are answered after a fixed memory latency. Other requests need a message to one or more caches first: invalidations to sharers, or a recall to the owner. For these the block opens a single transaction, marks the entry busy and counts acknowledgements. It replies to the requester only after the final acknowledgement. Any request to a busy entry is refused with a NACK, and the requester retries later. Because a write's data leaves the home only after every other copy is gone, writes appear atomic to all nodes.

Top module: `dir_home`

## Requirements
- R1: After reset every presence bit and dirty bit is clear, no entry is busy, `nack_valid`, `msg_valid` and `rsp_valid` are low, and memory block a holds (3*a+1) modulo 2^DW.
- R2: A read to a clean block from a node that is not the owner is accepted without a message. The node's presence bit is set, and the reply carries the block's memory value with `rsp_excl`=0. It is valid MEM_LAT cycles after the accepting edge, counting the cycle after that edge as the first.
- R3: A read to a dirty block from a non-owner emits, in the cycle after acceptance, a message of kind 1 (recall-to-shared) whose mask holds only the owner. On the acknowledgement, memory takes `ack_data` and dirty clears. The owner keeps its presence bit, the requester's bit is set, and the reply carries `ack_data` with `rsp_excl`=0.
- R4: A write to a clean block sends, in the cycle after acceptance, a message of kind 0 (invalidate) whose mask is the presence set minus the requester. The transaction then waits for one acknowledgement per mask bit. With no other sharer, no message is sent and the reply follows as in R2 with `rsp_excl`=1.
- R5: A write to a dirty block from a non-owner emits a message of kind 2 (recall-and-invalidate) to the owner. On the acknowledgement, memory takes `ack_data` and the reply carries that value with `rsp_excl`=1.
- R6: The reply for a transaction is withheld until its final acknowledgement. It is valid MEM_LAT cycles after the edge that takes that acknowledgement. After a write completes, only the writer's presence bit is set and dirty is set.
- R7: A request to a busy entry is refused. `nack_valid` is high with `nack_node` equal to the requester in the cycle after the request, and the directory entry is left unchanged.
- R8: Only one transaction is open at a time. A request that would need messages while another transaction is open is refused with a NACK. A request to another block that needs no message is still served.
- R9: A request presented in the same cycle as the final acknowledgement of the open transaction is refused with a NACK.
- R10: A request from the current owner of a dirty block is answered as in R2 with memory's value, `rsp_excl` equal to the request's write flag, and the directory entry unchanged.
- R11: An acknowledgement while no transaction is open has no effect: no message, reply or NACK follows, and memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_node | input | NW | Requesting node |
| req_addr | input | AW | Block index |
| ack_valid | input | 1 | One acknowledgement for the open transaction |
| ack_data | input | DW | Line data returned with a recall acknowledgement |
| nack_valid | output | 1 | Refusal of the previous cycle's request |
| nack_node | output | NW | Node being refused |
| msg_valid | output | 1 | Coherence message to caches |
| msg_kind | output | 2 | 0 invalidate, 1 recall-to-shared, 2 recall-and-invalidate |
| msg_mask | output | NODES | Destination nodes, one bit each |
| msg_addr | output | AW | Block the message concerns |
| rsp_valid | output | 1 | Data reply to a requester |
| rsp_node | output | NW | Node receiving the reply |
| rsp_excl | output | 1 | Reply grants ownership |
| rsp_data | output | DW | Block data |

## Verification
NACKs and coherence messages are due in the first cycle after the request's edge. Data replies are due MEM_LAT cycles after the edge that accepts a directly served request, or after the edge that takes the final acknowledgement. The driver stamps each expected reply with its due cycle from a free-running cycle count. The monitor samples on the falling edge, pops the queue whenever a reply shows up, and compares node, data, ownership flag and arrival cycle. A reply that arrives early, for instance before the final acknowledgement, finds an empty queue or the wrong due cycle and is reported.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NODES   = 4,
  parameter int BLOCKS  = 16,
  parameter int DW      = 8,
  parameter int MEM_LAT = 2,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NW-1:0]    req_node,
  input  logic [AW-1:0]    req_addr,
  input  logic             ack_valid,
  input  logic [DW-1:0]    ack_data,
  output logic             nack_valid,
  output logic [NW-1:0]    nack_node,
  output logic             msg_valid,
  output logic [1:0]       msg_kind,
  output logic [NODES-1:0] msg_mask,
  output logic [AW-1:0]    msg_addr,
  output logic             rsp_valid,
  output logic [NW-1:0]    rsp_node,
  output logic             rsp_excl,
  output logic [DW-1:0]    rsp_data
);
  localparam int CW = $clog2(NODES + 1);
  localparam logic [1:0] K_INV = 2'd0, K_RSH = 2'd1, K_RINV = 2'd2;
  localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

  function automatic logic [CW-1:0] pop(input logic [NODES-1:0] v);
    pop = '0;
    for (int k = 0; k < NODES; k++) pop = pop + CW'(v[k]);
  endfunction

  logic [NODES-1:0] pres [BLOCKS];
  logic [BLOCKS-1:0] dirty, busy;
  logic [DW-1:0]    mem  [BLOCKS];

  logic          eng_busy, eng_write, eng_recall;
  logic [NW-1:0] eng_node;
  logic [AW-1:0] eng_addr;
  logic [CW-1:0] ack_cnt;

  wire [NODES-1:0] req_bit  = ONE << req_node;
  wire [NODES-1:0] eng_bit  = ONE << eng_node;
  wire [NODES-1:0] cur      = pres[req_addr];
  wire [NODES-1:0] others   = cur & ~req_bit;
  wire             owner_rq = dirty[req_addr] & cur[req_node];
  wire             last_ack = eng_busy & ack_valid & (ack_cnt == CW'(1));
  wire             need_eng = ~owner_rq & (dirty[req_addr] | (req_write & |others));
  wire             refuse   = busy[req_addr] | last_ack | (need_eng & eng_busy);
  wire             take     = req_valid & ~refuse;

  logic          push_v, push_x;
  logic [NW-1:0] push_n;
  logic [DW-1:0] push_d;

  always_comb begin
    push_v = 1'b0;
    push_x = 1'b0;
    push_n = req_node;
    push_d = mem[req_addr];
    if (last_ack) begin
      push_v = 1'b1;
      push_x = eng_write;
      push_n = eng_node;
      push_d = eng_recall ? ack_data : mem[eng_addr];
    end else if (take && !need_eng) begin
      push_v = 1'b1;
      push_x = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < BLOCKS; a++) begin
        pres[a] <= '0;
        mem[a]  <= DW'(3 * a + 1);
      end
      dirty      <= '0;
      busy       <= '0;
      eng_busy   <= 1'b0;
      eng_write  <= 1'b0;
      eng_recall <= 1'b0;
      eng_node   <= '0;
      eng_addr   <= '0;
      ack_cnt    <= '0;
      nack_valid <= 1'b0;
      nack_node  <= '0;
      msg_valid  <= 1'b0;
      msg_kind   <= K_INV;
      msg_mask   <= '0;
      msg_addr   <= '0;
    end else begin
      nack_valid <= req_valid & refuse;
      nack_node  <= req_node;
      msg_valid  <= 1'b0;
      if (take) begin
        if (need_eng) begin
          eng_busy       <= 1'b1;
          busy[req_addr] <= 1'b1;
          eng_addr       <= req_addr;
          eng_node       <= req_node;
          eng_write      <= req_write;
          eng_recall     <= dirty[req_addr];
          msg_valid      <= 1'b1;
          msg_addr       <= req_addr;
          if (dirty[req_addr]) begin
            msg_kind <= req_write ? K_RINV : K_RSH;
            msg_mask <= cur;
            ack_cnt  <= CW'(1);
          end else begin
            msg_kind <= K_INV;
            msg_mask <= others;
            ack_cnt  <= pop(others);
          end
        end else if (!owner_rq) begin
          if (req_write) begin
            pres[req_addr]  <= req_bit;
            dirty[req_addr] <= 1'b1;
          end else begin
            pres[req_addr] <= cur | req_bit;
          end
        end
      end
      if (eng_busy && ack_valid) begin
        ack_cnt <= ack_cnt - CW'(1);
        if (eng_recall) mem[eng_addr] <= ack_data;
        if (last_ack) begin
          eng_busy       <= 1'b0;
          busy[eng_addr] <= 1'b0;
          if (eng_write) begin
            pres[eng_addr]  <= eng_bit;
            dirty[eng_addr] <= 1'b1;
          end else begin
            pres[eng_addr]  <= pres[eng_addr] | eng_bit;
            dirty[eng_addr] <= 1'b0;
          end
        end
      end
    end
  end

  logic          pv [MEM_LAT];
  logic          px [MEM_LAT];
  logic [NW-1:0] pn [MEM_LAT];
  logic [DW-1:0] pd [MEM_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_LAT; k++) begin
        pv[k] <= 1'b0;
        px[k] <= 1'b0;
        pn[k] <= '0;
        pd[k] <= '0;
      end
    end else begin
      pv[0] <= push_v;
      px[0] <= push_x;
      pn[0] <= push_n;
      pd[0] <= push_d;
      for (int k = 1; k < MEM_LAT; k++) begin
        pv[k] <= pv[k-1];
        px[k] <= px[k-1];
        pn[k] <= pn[k-1];
        pd[k] <= pd[k-1];
      end
    end
  end

  assign rsp_valid = pv[MEM_LAT-1];
  assign rsp_excl  = px[MEM_LAT-1];
  assign rsp_node  = pn[MEM_LAT-1];
  assign rsp_data  = pd[MEM_LAT-1];

  p_one_busy_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(busy));
  p_nack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy[req_addr] |=> nack_valid && nack_node == $past(req_node));
  p_nack_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && last_ack |=> nack_valid);
  p_close_r6: assert property (@(posedge clk) disable iff (!rst_n) last_ack |=> !eng_busy);
  p_mask_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !msg_mask[eng_node] && msg_mask != '0);
  p_kind_r3: assert property (@(posedge clk) disable iff (!rst_n) msg_valid |-> msg_kind != 2'd3);
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !eng_busy && !req_valid |=> !msg_valid && !nack_valid);

  for (genvar g = 0; g < BLOCKS; g++) begin : g_own
    p_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dirty[g] |-> $onehot(pres[g]));
  end
endmodule

// File: tb/sim_dir_home.sv
`timescale 1ns/1ps
module sim_dir_home;
  localparam int NODES = 4, BLOCKS = 16, DW = 8, LAT = 2;
  localparam int NW = 2, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, ack_valid = 0;
  logic [NW-1:0] req_node = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] ack_data = '0;
  logic nack_valid, msg_valid, rsp_valid, rsp_excl;
  logic [NW-1:0] nack_node, rsp_node;
  logic [1:0] msg_kind;
  logic [NODES-1:0] msg_mask;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  dir_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW), .MEM_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_node(req_node), .req_addr(req_addr), .ack_valid(ack_valid), .ack_data(ack_data),
    .nack_valid(nack_valid), .nack_node(nack_node), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_mask(msg_mask), .msg_addr(msg_addr),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_excl(rsp_excl), .rsp_data(rsp_data));

  int total = 0, bad = 0, cyc = 0, t_drv = 0;
  logic g_nack, g_msg;
  logic [NW-1:0] g_nn;
  logic [1:0] g_kind;
  logic [NODES-1:0] g_mask;
  int q_node[$], q_data[$], q_excl[$], q_due[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int f(input int a);
    return (3 * a + 1) & 8'hFF;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_rsp(input int node, input int data, input int excl);
    q_node.push_back(node); q_data.push_back(data);
    q_excl.push_back(excl); q_due.push_back(t_drv + LAT);
  endtask

  task automatic grab();
    g_nack = nack_valid; g_nn = nack_node; g_msg = msg_valid;
    g_kind = msg_kind; g_mask = msg_mask;
  endtask

  task automatic do_req(input logic w, input int node, input int addr);
    req_valid = 1; req_write = w; req_node = NW'(node); req_addr = AW'(addr); t_drv = cyc;
    @(negedge clk);
    req_valid = 0;
    grab();
  endtask

  task automatic do_ack(input int data, input logic with_req, input logic w,
                        input int node, input int addr);
    ack_valid = 1; ack_data = DW'(data); t_drv = cyc;
    req_valid = with_req; req_write = w; req_node = NW'(node); req_addr = AW'(addr);
    @(negedge clk);
    ack_valid = 0; req_valid = 0;
    grab();
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (q_node.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected reply: actual node=%0d data=%0d expected none", rsp_node, rsp_data);
      end else begin
        int n, d, x, t;
        n = q_node.pop_front(); d = q_data.pop_front();
        x = q_excl.pop_front(); t = q_due.pop_front();
        if (rsp_node != NW'(n) || rsp_data != DW'(d) || rsp_excl != x[0] || cyc != t) begin
          bad++;
          $display("FAIL R2 reply: actual node=%0d data=%0d excl=%0d cyc=%0d expected node=%0d data=%0d excl=%0d cyc=%0d",
                   rsp_node, rsp_data, rsp_excl, cyc, n, d, x, t);
        end
      end
    end
  end

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 nack", nack_valid, 0);
    chk("R1 msg", msg_valid, 0);
    chk("R1 rsp", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    do_req(0, 1, 3); chk("R2 no msg", g_msg, 0); chk("R2 no nack", g_nack, 0); exp_rsp(1, f(3), 0);
    do_req(0, 2, 3); exp_rsp(2, f(3), 0);
    do_req(0, 3, 0); exp_rsp(3, f(0), 0);
    do_req(0, 3, 15); exp_rsp(3, f(15), 0);

    do_req(1, 0, 3);
    chk("R4 msg", g_msg, 1); chk("R4 kind", g_kind, 0); chk("R4 mask", g_mask, 4'b0110);
    do_req(0, 3, 3);
    chk("R7 nack", g_nack, 1); chk("R7 nack node", g_nn, 3); chk("R7 no msg", g_msg, 0);
    do_req(1, 3, 5); chk("R8 served", g_nack, 0); exp_rsp(3, f(5), 1);
    do_req(0, 1, 5); chk("R8 refused", g_nack, 1);
    do_ack(8'h99, 0, 0, 0, 0); chk("R6 held", g_msg, 0);
    do_ack(8'h99, 1, 0, 2, 7); chk("R9 nack", g_nack, 1); chk("R9 node", g_nn, 2);
    exp_rsp(0, f(3), 1);
    repeat (3) @(negedge clk);

    do_req(1, 1, 3);
    chk("R6 owner only", g_mask, 4'b0001); chk("R5 kind", g_kind, 2);
    do_ack(8'hC3, 0, 0, 0, 0); exp_rsp(1, 8'hC3, 1);

    do_req(0, 2, 3);
    chk("R3 kind", g_kind, 1); chk("R3 mask", g_mask, 4'b0010);
    do_ack(8'h77, 0, 0, 0, 0); exp_rsp(2, 8'h77, 0);
    do_req(0, 0, 3); chk("R3 clean after recall", g_msg, 0); exp_rsp(0, 8'h77, 0);
    do_req(1, 0, 3);
    chk("R3 owner kept", g_mask, 4'b0110); chk("R4 kind again", g_kind, 0);
    do_ack(0, 0, 0, 0, 0);
    do_ack(0, 0, 0, 0, 0); exp_rsp(0, 8'h77, 1);
    repeat (3) @(negedge clk);

    do_req(1, 0, 3); chk("R10 write no msg", g_msg, 0); exp_rsp(0, 8'h77, 1);
    do_req(0, 0, 3); chk("R10 read no msg", g_msg, 0); exp_rsp(0, 8'h77, 0);
    do_req(1, 2, 3); chk("R10 unchanged", g_mask, 4'b0001); chk("R10 kind", g_kind, 2);
    do_ack(8'h11, 0, 0, 0, 0); exp_rsp(2, 8'h11, 1);
    repeat (3) @(negedge clk);

    do_ack(8'hEE, 0, 0, 0, 0);
    chk("R11 no msg", g_msg, 0); chk("R11 no nack", g_nack, 0);
    repeat (3) @(negedge clk);
    do_req(0, 1, 9); exp_rsp(1, f(9), 0);
    do_req(1, 1, 3); chk("R11 recall needed", g_mask, 4'b0100);
    repeat (4) @(negedge clk);
    do_ack(8'h42, 0, 0, 0, 0); exp_rsp(1, 8'h42, 1);
    do_req(0, 3, 3); chk("R11 recall data", g_kind, 1);
    do_ack(8'h43, 0, 0, 0, 0); exp_rsp(3, 8'h43, 0);

    repeat (6) @(negedge clk);
    chk("R6 all replies seen", q_node.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule